// File: doc/BRIEF.md
# Serial Register Bus Streaming Slave

This block is a synchronous serial slave that sits between a host controller and two byte FIFOs. The host lowers a chip select and clocks an 8-bit address byte into the block. While chip select stays low, the host may clock any number of data bytes after it, with no new address. A streaming write address sends every received byte into a write FIFO. A streaming read address returns successive bytes taken from a read FIFO. Other addresses reach a few plain byte registers, and the same register is accessed again for every further data byte in the burst.

The serial pins are oversampled by the block's system clock. The serial clock idles high. The command line is sampled on each rising serial clock edge. The read line changes after each falling edge and carries an explicit drive enable, so it is high-impedance whenever no data is being returned. A core-side port drains the write FIFO and fills the read FIFO. Both FIFOs present their head entry before it is popped.

Top module: `serstream_slave`

## Requirements
- R1: Address and data bytes are shifted most significant bit first. Bit 7 of the address byte selects a read (1) or a write (0), and bits 6..0 choose the target: 0x01 write FIFO port, 0x02 read FIFO port, 0x03 scratch register, 0x04 write FIFO level, 0x05 read FIFO level, 0x06 flags.
- R2: In a write to 0x01, every complete data byte that follows the address in the same chip-select window is pushed as its own write FIFO entry, in arrival order.
- R3: The write FIFO holds 128 entries. A byte written while it is full is dropped and sets the overflow flag (flags bit 0), which stays set until cleared.
- R4: In a read from 0x02, each data byte pops the next read FIFO entry. Its bit 7 is driven after the first falling edge of that byte, and each later falling edge presents the next lower bit. A one-byte transaction returns the same byte as the corresponding byte of a burst.
- R5: A read of 0x02 while the read FIFO is empty returns 0x00 and sets the underflow flag (flags bit 1), which stays set until cleared.
- R6: The read drive enable is low while the address byte is shifted, during write transactions and while chip select is high. It is high during every data bit of a read.
- R7: Raising chip select ends the transaction at any bit. A partial data byte is never committed, and a partial address byte leaves no state behind.
- R8: A 128-byte write FIFO fill gives the same contents whether it is sent as one burst, as 128 one-byte transactions or as 64 two-byte transactions.
- R9: Registers 0x04 and 0x05 read the current fill level of the write and read FIFO (0 to 128). Writes to them have no effect.
- R10: The scratch register returns the last byte written to it, including the last byte of a burst. Writing the flags register clears each flag whose bit is 1. Reads of unmapped addresses return 0x00.
- R11: On the core side, the write FIFO head is visible on coreWrData until popped. Pushes into a full read FIFO are dropped, and coreRdFull reports a full read FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock, idles high |
| cmdIn | input | 1 | Serial command/data input from the host |
| rdOut | output | 1 | Serial read data value |
| rdOe | output | 1 | Drive enable for the read line (low means high-impedance) |
| coreWrPop | input | 1 | Core pops the write FIFO head |
| coreWrData | output | 8 | Write FIFO head entry |
| coreWrEmpty | output | 1 | Write FIFO is empty |
| coreRdPush | input | 1 | Core pushes a byte into the read FIFO |
| coreRdData | input | 8 | Byte pushed by the core |
| coreRdFull | output | 1 | Read FIFO is full |

## Verification
The bench fills the write FIFO in all three split patterns and checks every entry on the core side. A design that lost or repeated a byte at a transaction boundary would fail there. Further checks write one byte past 128 and read past the end of the read FIFO, which catch a design that wraps over old data or returns stale bytes, and that the sticky flags set and clear. Chip select is raised inside an address byte and inside a data byte, which exposes a bit counter that is not reset or a half byte that gets committed. The drive enable is sampled at every bit, so a read line driven during the address byte or during writes is reported.

// File: rtl/serstream_pkg.sv
`timescale 1ns/1ps
package serstream_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_WR_PORT  = 7'h01;
  localparam logic [ADDR_W-1:0] ADDR_RD_PORT  = 7'h02;
  localparam logic [ADDR_W-1:0] ADDR_SCRATCH  = 7'h03;
  localparam logic [ADDR_W-1:0] ADDR_WR_LEVEL = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_RD_LEVEL = 7'h05;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS    = 7'h06;

  // Strobes from control to datapath, one system clock wide each
  typedef struct packed {
    logic              shiftIn;  // sample cmd bit into rx shifter
    logic              commit;   // complete write data byte is ready
    logic              txLoad;   // first falling edge of a read byte
    logic              txShift;  // later falling edge of a read byte
    logic              oeClr;    // chip select idle
    logic [ADDR_W-1:0] regAddr;  // latched target address
  } strobes_t;
endpackage

// File: rtl/serstream_fifo.sv
`timescale 1ns/1ps
module serstream_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           push,
  input  logic [W-1:0]                   din,
  input  logic                           pop,
  output logic [W-1:0]                   dout,
  output logic                           full,
  output logic                           empty,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: a push into a full FIFO with no pop leaves the level unchanged
  p_full_push_dropped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> $stable(count));

  // R5: a pop from an empty FIFO with no push leaves the level unchanged
  p_empty_pop_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> $stable(count));
endmodule

// File: rtl/serstream_ctrl.sv
`timescale 1ns/1ps
module serstream_ctrl
  import serstream_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        cmdIn,
  input  logic [7:0]  rxByteNext,
  output logic        cmdBit,
  output strobes_t    st
);
  logic [2:0]        sclkSync;
  logic [1:0]        csSync;
  logic [1:0]        cmdSync;
  logic              sclkRise, sclkFall, csActive;
  logic [2:0]        bitCnt;
  logic              addrDone;
  logic              isRead;
  logic [ADDR_W-1:0] regAddr;

  // Two-flop synchronisers; the third sclk stage feeds edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '1;
      csSync   <= '1;
      cmdSync  <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      csSync   <= {csSync[0], csN};
      cmdSync  <= {cmdSync[0], cmdIn};
    end
  end

  assign sclkRise = sclkSync[1] && !sclkSync[2];
  assign sclkFall = !sclkSync[1] && sclkSync[2];
  assign csActive = !csSync[1];
  assign cmdBit   = cmdSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      addrDone <= 1'b0;
      isRead   <= 1'b0;
      regAddr  <= '0;
    end else if (!csActive) begin
      bitCnt   <= '0;
      addrDone <= 1'b0;
    end else if (sclkRise) begin
      bitCnt <= bitCnt + 1'b1;
      if (bitCnt == 3'd7 && !addrDone) begin
        addrDone <= 1'b1;
        isRead   <= rxByteNext[7];
        regAddr  <= rxByteNext[ADDR_W-1:0];
      end
    end
  end

  always_comb begin
    st.shiftIn = csActive && sclkRise;
    st.commit  = csActive && sclkRise && (bitCnt == 3'd7) && addrDone && !isRead;
    st.txLoad  = csActive && sclkFall && addrDone && isRead && (bitCnt == 3'd0);
    st.txShift = csActive && sclkFall && addrDone && isRead && (bitCnt != 3'd0);
    st.oeClr   = !csActive;
    st.regAddr = regAddr;
  end

  // R7: an idle chip select clears the bit position and the address phase
  p_idle_resets_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> (bitCnt == 3'd0 && !addrDone));

  // R2: a committed write byte always follows a finished address byte
  p_commit_after_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |-> $past(csActive));
endmodule

// File: rtl/serstream_dp.sv
`timescale 1ns/1ps
module serstream_dp
  import serstream_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobes_t    st,
  input  logic        cmdBit,
  output logic [7:0]  rxByteNext,
  output logic        rdOut,
  output logic        rdOe,
  input  logic        coreWrPop,
  output logic [7:0]  coreWrData,
  output logic        coreWrEmpty,
  input  logic        coreRdPush,
  input  logic [7:0]  coreRdData,
  output logic        coreRdFull
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [6:0]       rxShift;
  logic [6:0]       txReg;
  logic [7:0]       scratchReg;
  logic             overflowFlag, underflowFlag;
  logic [CNT_W-1:0] wrCount, rdCount;
  logic             wrFull, rdEmpty;
  logic [7:0]       rdHead;
  logic             hitWrPort, hitRdPort, wrPush, rdPop;
  logic             ovfSet, unfSet, ovfClr, unfClr;
  logic [7:0]       txValue;

  assign rxByteNext = {rxShift, cmdBit};
  assign hitWrPort  = (st.regAddr == ADDR_WR_PORT);
  assign hitRdPort  = (st.regAddr == ADDR_RD_PORT);
  assign wrPush     = st.commit && hitWrPort;
  assign rdPop      = st.txLoad && hitRdPort && !rdEmpty;
  assign ovfSet     = wrPush && wrFull;
  assign unfSet     = st.txLoad && hitRdPort && rdEmpty;
  assign ovfClr     = st.commit && (st.regAddr == ADDR_FLAGS) && rxByteNext[0];
  assign unfClr     = st.commit && (st.regAddr == ADDR_FLAGS) && rxByteNext[1];

  serstream_fifo #(.W(8), .DEPTH(DEPTH)) u_wrFifo (
    .clk(clk), .rstN(rstN),
    .push(wrPush), .din(rxByteNext),
    .pop(coreWrPop), .dout(coreWrData),
    .full(wrFull), .empty(coreWrEmpty), .count(wrCount)
  );

  serstream_fifo #(.W(8), .DEPTH(DEPTH)) u_rdFifo (
    .clk(clk), .rstN(rstN),
    .push(coreRdPush), .din(coreRdData),
    .pop(rdPop), .dout(rdHead),
    .full(coreRdFull), .empty(rdEmpty), .count(rdCount)
  );

  // Byte presented for the read data byte that is starting
  always_comb begin
    case (st.regAddr)
      ADDR_RD_PORT:  txValue = rdEmpty ? 8'h00 : rdHead;
      ADDR_SCRATCH:  txValue = scratchReg;
      ADDR_WR_LEVEL: txValue = 8'(wrCount);
      ADDR_RD_LEVEL: txValue = 8'(rdCount);
      ADDR_FLAGS:    txValue = {6'b0, underflowFlag, overflowFlag};
      default:       txValue = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift       <= '0;
      txReg         <= '0;
      rdOut         <= 1'b0;
      rdOe          <= 1'b0;
      scratchReg    <= '0;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      if (st.shiftIn) rxShift <= rxByteNext[6:0];

      if (st.commit && st.regAddr == ADDR_SCRATCH) scratchReg <= rxByteNext;

      if (ovfSet)      overflowFlag <= 1'b1;
      else if (ovfClr) overflowFlag <= 1'b0;
      if (unfSet)      underflowFlag <= 1'b1;
      else if (unfClr) underflowFlag <= 1'b0;

      if (st.oeClr) begin
        rdOe <= 1'b0;
      end else if (st.txLoad) begin
        rdOe  <= 1'b1;
        rdOut <= txValue[7];
        txReg <= txValue[6:0];
      end else if (st.txShift) begin
        rdOut <= txReg[6];
        txReg <= {txReg[5:0], 1'b0};
      end
    end
  end

  // R5: a byte started on an empty read FIFO drives zero and flags underflow
  p_underflow_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.txLoad && hitRdPort && rdEmpty) |=> (!rdOut && underflowFlag));

  // R3: the overflow flag holds until a clearing write
  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlag && !ovfClr) |=> overflowFlag);

  // R6: the read line is only enabled by the start of a read data byte
  p_oe_needs_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdOe) |-> $past(st.txLoad));

  // R6: an idle chip select releases the read line
  p_oe_idle_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.oeClr |=> !rdOe);
endmodule

// File: rtl/serstream_slave.sv
`timescale 1ns/1ps
module serstream_slave
  import serstream_pkg::*;
#(
  parameter int FIFO_DEPTH = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       cmdIn,
  output logic       rdOut,
  output logic       rdOe,
  input  logic       coreWrPop,
  output logic [7:0] coreWrData,
  output logic       coreWrEmpty,
  input  logic       coreRdPush,
  input  logic [7:0] coreRdData,
  output logic       coreRdFull
);
  strobes_t   st;
  logic       cmdBit;
  logic [7:0] rxByteNext;

  serstream_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .cmdIn(cmdIn),
    .rxByteNext(rxByteNext), .cmdBit(cmdBit), .st(st)
  );

  serstream_dp #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cmdBit(cmdBit),
    .rxByteNext(rxByteNext), .rdOut(rdOut), .rdOe(rdOe),
    .coreWrPop(coreWrPop), .coreWrData(coreWrData), .coreWrEmpty(coreWrEmpty),
    .coreRdPush(coreRdPush), .coreRdData(coreRdData), .coreRdFull(coreRdFull)
  );
endmodule

// File: tb/tb_serstream_slave.sv
`timescale 1ns/1ps
module tb_serstream_slave;
  import serstream_pkg::*;
  localparam int DEPTH = 128;
  localparam int HALF  = 6;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b1, cmdIn = 1'b0;
  logic coreWrPop = 1'b0, coreRdPush = 1'b0;
  logic [7:0] coreRdData = 8'h00;
  logic rdOut, rdOe, coreWrEmpty, coreRdFull;
  logic [7:0] coreWrData;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int oeAddrHigh, oeDataHigh, dataBits;

  always #4 clk = ~clk;

  serstream_slave #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .cmdIn(cmdIn),
    .rdOut(rdOut), .rdOe(rdOe),
    .coreWrPop(coreWrPop), .coreWrData(coreWrData), .coreWrEmpty(coreWrEmpty),
    .coreRdPush(coreRdPush), .coreRdData(coreRdData), .coreRdFull(coreRdFull)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'(i * 37 + seed * 11 + 1);
  endfunction

  task automatic shiftByte(input logic [7:0] tx, input int nBits, input bit isData,
                           output logic [7:0] rx);
    rx = 8'h00;
    for (int b = 7; b > 7 - nBits; b--) begin
      sclk = 1'b0;
      cmdIn = tx[b];
      tick(HALF);
      rx[b] = rdOut;
      if (isData) begin
        dataBits++;
        if (rdOe === 1'b1) oeDataHigh++;
      end else if (rdOe !== 1'b0) oeAddrHigh++;
      sclk = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic txBegin();
    oeAddrHigh = 0; oeDataHigh = 0; dataBits = 0;
    csN = 1'b0;
    tick(4);
  endtask

  task automatic txEnd();
    tick(3);
    csN = 1'b1;
    tick(6);
  endtask

  task automatic busWriteVal(input logic [6:0] a, input logic [7:0] v);
    logic [7:0] d;
    txBegin();
    shiftByte({1'b0, a}, 8, 1'b0, d);
    shiftByte(v, 8, 1'b1, d);
    txEnd();
  endtask

  task automatic busWriteBurst(input logic [6:0] a, input int first, input int n, input int seed);
    logic [7:0] d;
    txBegin();
    shiftByte({1'b0, a}, 8, 1'b0, d);
    for (int i = first; i < first + n; i++) shiftByte(pat(i, seed), 8, 1'b1, d);
    txEnd();
  endtask

  task automatic busRead(input logic [6:0] a, output logic [7:0] v);
    logic [7:0] d;
    txBegin();
    shiftByte({1'b1, a}, 8, 1'b0, d);
    shiftByte(8'h00, 8, 1'b1, v);
    txEnd();
  endtask

  task automatic drainCheck(input string tag, input int n, input int seed);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (coreWrEmpty !== 1'b0 || coreWrData !== pat(i, seed)) begin
        bad++;
        $display("FAIL %s entry %0d actual=%0h expected=%0h", tag, i, coreWrData, pat(i, seed));
      end
      coreWrPop = 1'b1;
      tick(1);
      coreWrPop = 1'b0;
    end
    chk({tag, " drained entries mismatching"}, bad, 0);
    chk({tag, " empty after drain"}, coreWrEmpty, 1);
  endtask

  task automatic corePush(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      coreRdData = pat(i, seed);
      coreRdPush = 1'b1;
      tick(1);
      coreRdPush = 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R0 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d;
    int bad;
    tick(10);
    rstN = 1'b1;
    tick(4);

    // Reset state
    chk("R6 rdOe low after reset", rdOe, 0);
    chk("R11 write FIFO empty after reset", coreWrEmpty, 1);
    chk("R11 read FIFO not full after reset", coreRdFull, 0);
    busRead(ADDR_WR_LEVEL, v);
    chk("R9 write level after reset", v, 0);
    chk("R6 no drive during address byte", oeAddrHigh, 0);
    chk("R6 drive during every read data bit", oeDataHigh, 8);
    chk("R6 rdOe released after chip select rise", rdOe, 0);

    // R8/R2: single 128-byte burst
    busWriteBurst(ADDR_WR_PORT, 0, DEPTH, 3);
    chk("R6 no drive during write data", oeDataHigh, 0);
    busRead(ADDR_WR_LEVEL, v);
    chk("R9 write level after 128-byte burst", v, 128);
    busRead(ADDR_FLAGS, v);
    chk("R3 no overflow at exactly 128", v, 0);
    drainCheck("R2 R8 burst fill", DEPTH, 3);

    // R8: 128 one-byte transactions, then R3 overflow
    for (int i = 0; i < DEPTH; i++) busWriteBurst(ADDR_WR_PORT, i, 1, 5);
    busRead(ADDR_WR_LEVEL, v);
    chk("R8 write level after single-byte fill", v, 128);
    busWriteVal(ADDR_WR_PORT, 8'hEE);
    busRead(ADDR_WR_LEVEL, v);
    chk("R3 level stays 128 on overflow", v, 128);
    busRead(ADDR_FLAGS, v);
    chk("R3 overflow flag set", v, 8'h01);
    drainCheck("R3 R8 single fill, extra byte dropped", DEPTH, 5);
    busRead(ADDR_FLAGS, v);
    chk("R3 overflow flag sticky after drain", v, 8'h01);
    busWriteVal(ADDR_FLAGS, 8'h01);
    busRead(ADDR_FLAGS, v);
    chk("R10 overflow flag cleared by write-one", v, 0);

    // R8: 64 two-byte transactions
    for (int k = 0; k < DEPTH / 2; k++) busWriteBurst(ADDR_WR_PORT, 2 * k, 2, 9);
    busRead(ADDR_WR_LEVEL, v);
    chk("R8 write level after paired fill", v, 128);
    drainCheck("R8 paired fill", DEPTH, 9);

    // R7: partial data byte discarded
    txBegin();
    shiftByte({1'b0, ADDR_WR_PORT}, 8, 1'b0, d);
    shiftByte(8'hC3, 5, 1'b1, d);
    txEnd();
    busRead(ADDR_WR_LEVEL, v);
    chk("R7 partial byte not committed", v, 0);
    txBegin();
    shiftByte({1'b0, ADDR_WR_PORT}, 8, 1'b0, d);
    shiftByte(8'h5A, 8, 1'b1, d);
    shiftByte(8'hFF, 4, 1'b1, d);
    txEnd();
    busRead(ADDR_WR_LEVEL, v);
    chk("R7 only complete byte committed", v, 1);
    chk("R7 committed byte value", coreWrData, 8'h5A);
    coreWrPop = 1'b1; tick(1); coreWrPop = 1'b0;

    // R7: partial address byte then a clean transaction
    busWriteVal(ADDR_SCRATCH, 8'h96);
    txBegin();
    shiftByte(8'h81, 3, 1'b0, d);
    txEnd();
    busRead(ADDR_SCRATCH, v);
    chk("R7 partial address leaves no state", v, 8'h96);

    // R1/R10: scratch, bit order, unmapped, read-only levels
    txBegin();
    shiftByte({1'b0, ADDR_SCRATCH}, 8, 1'b0, d);
    shiftByte(8'h11, 8, 1'b1, d);
    shiftByte(8'h22, 8, 1'b1, d);
    shiftByte(8'h3C, 8, 1'b1, d);
    txEnd();
    busRead(ADDR_SCRATCH, v);
    chk("R10 scratch keeps last burst byte", v, 8'h3C);
    busWriteVal(ADDR_SCRATCH, 8'hA5);
    busRead(ADDR_SCRATCH, v);
    chk("R1 MSB-first scratch round trip", v, 8'hA5);
    busRead(7'h41, v);
    chk("R1 R10 bit-reversed address is unmapped", v, 0);
    busWriteVal(ADDR_WR_LEVEL, 8'hFF);
    busRead(ADDR_WR_LEVEL, v);
    chk("R9 write to level register ignored", v, 0);

    // R4: streaming read burst
    corePush(20, 11);
    busRead(ADDR_RD_LEVEL, v);
    chk("R9 read level after 20 pushes", v, 20);
    txBegin();
    shiftByte({1'b1, ADDR_RD_PORT}, 8, 1'b0, d);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      shiftByte(8'h00, 8, 1'b1, v);
      if (v !== pat(i, 11)) begin
        bad++;
        $display("FAIL R4 burst byte %0d actual=%0h expected=%0h", i, v, pat(i, 11));
      end
    end
    txEnd();
    chk("R4 burst read mismatches", bad, 0);
    chk("R6 drive during all burst data bits", oeDataHigh, dataBits);
    chk("R6 no drive during read address", oeAddrHigh, 0);

    // R4: one-byte read transactions
    corePush(2, 13);
    busRead(ADDR_RD_PORT, v);
    chk("R4 single-byte read first", v, pat(0, 13));
    busRead(ADDR_RD_PORT, v);
    chk("R4 single-byte read second", v, pat(1, 13));
    busRead(ADDR_FLAGS, v);
    chk("R5 no underflow yet", v, 0);

    // R5: read past the end
    corePush(1, 20);
    txBegin();
    shiftByte({1'b1, ADDR_RD_PORT}, 8, 1'b0, d);
    shiftByte(8'h00, 8, 1'b1, v);
    chk("R4 last real byte", v, pat(0, 20));
    shiftByte(8'h00, 8, 1'b1, v);
    chk("R5 empty read returns zero", v, 0);
    shiftByte(8'h00, 8, 1'b1, v);
    chk("R5 second empty read returns zero", v, 0);
    txEnd();
    busRead(ADDR_FLAGS, v);
    chk("R5 underflow flag set", v, 8'h02);
    busWriteVal(ADDR_FLAGS, 8'h02);
    busRead(ADDR_FLAGS, v);
    chk("R10 underflow flag cleared", v, 0);

    // R11/R9: read FIFO full, drop extra core pushes
    corePush(DEPTH + 2, 17);
    chk("R11 read FIFO full", coreRdFull, 1);
    busRead(ADDR_RD_LEVEL, v);
    chk("R9 read level at 128", v, 128);
    txBegin();
    shiftByte({1'b1, ADDR_RD_PORT}, 8, 1'b0, d);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      shiftByte(8'h00, 8, 1'b1, v);
      if (v !== pat(i, 17)) bad++;
    end
    txEnd();
    chk("R4 R11 full read FIFO drained in order", bad, 0);
    busRead(ADDR_RD_LEVEL, v);
    chk("R9 read level back to 0", v, 0);
    busRead(ADDR_FLAGS, v);
    chk("R5 no underflow for exact drain", v, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule